// File: doc/BRIEF.md
# Lockable Serial Number Register

This block holds a 64-bit identification value as eight byte-wide registers behind a simple byte-addressed register port, plus a control register. A host uses the port to program the identification bytes, and it may rewrite them as often as it likes. When the value is final, the host sets a single lock flag in the control register. From that point the identification bytes are write-protected for good. The flag itself cannot be taken back by any register access. Reads of every byte keep working as before.

The port has an address, write data and write enable, all sampled on the rising clock edge. Read data is a combinational function of the address and the current register contents. The identification bytes sit at consecutive addresses starting at 11h. The control register sits at 0Bh, and its bit 7 is the lock flag. Only a hardware reset of the block clears the lock. Nonvolatile retention is represented by ordinary register state.

Top module: `idtag_store`

## Requirements
- R1: After reset, every identification byte (11h to 18h) and the control register (0Bh) read as 00h, so the lock flag is 0.
- R2: While unlocked, a write to address 11h+i (i = 0..7) stores the write data in byte i. From the next clock edge onward, a read of that address returns the stored value, and no other byte changes.
- R3: While unlocked, a byte may be rewritten any number of times, and the last write wins.
- R4: A write to 0Bh with write-data bit 7 = 1 sets the lock flag. It reads back as bit 7 of 0Bh from the next clock edge onward.
- R5: Once the lock flag is 1, writes to addresses 11h to 18h leave all identification bytes unchanged.
- R6: Once set, the lock flag stays 1. This holds when 0Bh is written with bit 7 = 0 and when any other address is accessed.
- R7: After locking, reads of 11h to 18h still return the stored identification bytes.
- R8: Bits 6..0 of 0Bh take the written value on every write to 0Bh, whether the block is locked or not.
- R9: Addresses outside 0Bh and 11h..18h read as 00h, and writes to them change no register.
- R10: An asserted reset (rst_n low) clears the lock flag and all bytes. After reset, the identification bytes are writable again.
- R11: Reset is applied asynchronously and released synchronously. Registers leave reset only after rst_n has been high for the synchronizer depth in clock edges (2 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable, one write per cycle in which it is high |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
The bench builds the block with its default parameters: eight identification bytes based at 11h, the control register at 0Bh with the lock on bit 7, and a two-stage reset synchronizer. With an 8-bit address, every one of the 256 addresses can be swept for writes and reads. This exposes any decode that aliases onto the identification bytes or the lock. The lock is then exercised across a full reset cycle, which reaches the only path that clears it.

// File: rtl/idtag_pkg.sv
package idtag_pkg;

  // Target of a register access after address decode
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_CTRL = 2'd2
  } idtag_sel_e;

endpackage

// File: rtl/idtag_rst_sync.sv
module idtag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/idtag_decode.sv
module idtag_decode
  import idtag_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ID_BYTES  = 8,
  parameter int ID_BASE   = 'h11,
  parameter int CTRL_ADDR = 'h0B,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output idtag_sel_e        sel,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
    for (int i = 0; i < ID_BYTES; i++) begin
      if (addr == ADDR_W'(ID_BASE + i)) begin
        sel = SEL_ID;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/idtag_ctrl_reg.sv
module idtag_ctrl_reg #(
  parameter int DATA_W   = 8,
  parameter int LOCK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              locked
);

  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_en;

  // Lock bit may only be OR-ed in; the remaining bits follow the write data
  always_comb begin
    ctrl_en = wr_en;
    ctrl_d  = (wdata & ~LOCK_MASK) | ((wdata | ctrl_q) & LOCK_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign locked = ctrl_q[LOCK_BIT];

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked)
    else $error("lock flag dropped");

  p_lock_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[LOCK_BIT]) |=> locked)
    else $error("lock write did not set the flag");

  p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((ctrl_q ^ $past(wdata)) & ~LOCK_MASK) == '0))
    else $error("control bits beside the lock not written");

endmodule

// File: rtl/idtag_byte_bank.sv
module idtag_byte_bank #(
  parameter int DATA_W   = 8,
  parameter int ID_BYTES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ID_BYTES-1:0]              wr_en,
  input  logic                             locked,
  input  logic [DATA_W-1:0]                wdata,
  output logic [ID_BYTES-1:0][DATA_W-1:0]  bytes_q
);

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_byte
    logic              en;
    logic [DATA_W-1:0] d;

    always_comb begin
      en = wr_en[g] && !locked;
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bytes_q[g] <= '0;
      else if (en) bytes_q[g] <= d;
    end

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(bytes_q[g]))
      else $error("identification byte changed while locked");

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[g] && !locked) |=> (bytes_q[g] == $past(wdata)))
      else $error("unlocked write not stored");
  end

endmodule

// File: rtl/idtag_store.sv
module idtag_store
  import idtag_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ID_BYTES    = 8,
  parameter int ID_BASE     = 'h11,
  parameter int CTRL_ADDR   = 'h0B,
  parameter int LOCK_BIT    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  logic                            rst_sync_n;
  idtag_sel_e                      sel;
  logic [IDX_W-1:0]                idx;
  logic [ID_BYTES-1:0]             id_we;
  logic                            ctrl_we;
  logic [DATA_W-1:0]               ctrl_q;
  logic                            locked;
  logic [ID_BYTES-1:0][DATA_W-1:0] bytes_q;

  idtag_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  idtag_decode #(
    .ADDR_W   (ADDR_W),
    .ID_BYTES (ID_BYTES),
    .ID_BASE  (ID_BASE),
    .CTRL_ADDR(CTRL_ADDR),
    .IDX_W    (IDX_W)
  ) i_decode (
    .addr (reg_addr),
    .sel  (sel),
    .idx  (idx)
  );

  always_comb begin
    ctrl_we = reg_we && (sel == SEL_CTRL);
    id_we   = '0;
    if (reg_we && (sel == SEL_ID)) id_we[idx] = 1'b1;
  end

  idtag_ctrl_reg #(
    .DATA_W  (DATA_W),
    .LOCK_BIT(LOCK_BIT)
  ) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (ctrl_we),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q),
    .locked (locked)
  );

  idtag_byte_bank #(
    .DATA_W  (DATA_W),
    .ID_BYTES(ID_BYTES)
  ) i_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (id_we),
    .locked  (locked),
    .wdata   (reg_wdata),
    .bytes_q (bytes_q)
  );

  always_comb begin
    unique case (sel)
      SEL_ID:   reg_rdata = bytes_q[idx];
      SEL_CTRL: reg_rdata = ctrl_q;
      default:  reg_rdata = '0;
    endcase
  end

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_NONE) |-> (reg_rdata == '0))
    else $error("unmapped address returned data");

  p_onehot_we_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({id_we, ctrl_we}))
    else $error("more than one register written at once");

  p_rst_hold_r11: assert property (@(posedge clk)
    !rst_n |=> !rst_sync_n)
    else $error("reset released too early");

endmodule

// File: tb/test_idtag_store.sv
module test_idtag_store;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] exp_id [8];
  logic [7:0] exp_ctrl;

  always #10 clk = ~clk;

  idtag_store i_idtag_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(8'h11 + 8'(i), v);
      check(req, v, exp_id[i]);
    end
    rd(8'h0B, v);
    check(req, v, exp_ctrl);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) exp_id[i] = 8'h00;
    exp_ctrl = 8'h00;
  endtask

  task automatic t_reset_release_r11();
    logic [7:0] v;
    do_reset();
    // rst_n rose at a negedge; the first posedge still holds reset internally
    reg_addr = 8'h11; reg_wdata = 8'h5A; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(8'h11, v);
    check("R11", v, 8'h00);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state_r1();
    check_all("R1");
  endtask

  task automatic t_write_read_r2();
    for (int i = 0; i < 8; i++) begin
      wr(8'h11 + 8'(i), 8'h30 + 8'(i * 7));
      exp_id[i] = 8'h30 + 8'(i * 7);
    end
    check_all("R2");
    wr(8'h14, 8'hC3);
    exp_id[3] = 8'hC3;
    check_all("R2");
  endtask

  task automatic t_rewrite_r3();
    for (int k = 0; k < 5; k++) wr(8'h18, 8'h10 * 8'(k) + 8'h01);
    exp_id[7] = 8'h41;
    wr(8'h11, 8'hFF);
    wr(8'h11, 8'h00);
    exp_id[0] = 8'h00;
    check_all("R3");
  endtask

  task automatic t_unmapped_r9();
    logic [7:0] v;
    for (int a = 0; a < 256; a++) begin
      if (a != 'h0B && (a < 'h11 || a > 'h18)) begin
        wr(8'(a), 8'hA5);
        rd(8'(a), v);
        if (a % 37 == 0) check("R9", v, 8'h00);
      end
    end
    check_all("R9");
  endtask

  task automatic t_lock_r4();
    logic [7:0] v;
    wr(8'h0B, 8'h85);
    exp_ctrl = 8'h85;
    rd(8'h0B, v);
    check("R4", v, 8'h85);
  endtask

  task automatic t_locked_writes_r5();
    for (int i = 0; i < 8; i++) wr(8'h11 + 8'(i), 8'hEE - 8'(i));
    check_all("R5");
  endtask

  task automatic t_clear_attempt_r6();
    logic [7:0] v;
    wr(8'h0B, 8'h00);
    exp_ctrl = 8'h80;
    rd(8'h0B, v);
    check("R6", v, 8'h80);
    wr(8'h0A, 8'h00);
    wr(8'h0C, 8'h00);
    wr(8'h8B, 8'h00);
    rd(8'h0B, v);
    check("R6", v, 8'h80);
  endtask

  task automatic t_locked_reads_r7();
    check_all("R7");
  endtask

  task automatic t_low_bits_r8();
    logic [7:0] v;
    wr(8'h0B, 8'h7F);
    exp_ctrl = 8'hFF;
    rd(8'h0B, v);
    check("R8", v, 8'hFF);
    wr(8'h0B, 8'h2A);
    exp_ctrl = 8'hAA;
    rd(8'h0B, v);
    check("R8", v, 8'hAA);
  endtask

  task automatic t_reset_clears_r10();
    logic [7:0] v;
    do_reset();
    repeat (3) @(negedge clk);
    check_all("R10");
    wr(8'h15, 8'h66);
    exp_id[4] = 8'h66;
    rd(8'h15, v);
    check("R10", v, 8'h66);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    t_reset_release_r11();
    t_reset_state_r1();
    t_write_read_r2();
    t_rewrite_r3();
    t_unmapped_r9();
    t_lock_r4();
    t_locked_writes_r5();
    t_clear_attempt_r6();
    t_locked_reads_r7();
    t_low_bits_r8();
    t_unmapped_r9();
    t_reset_clears_r10();
    summary();
    $finish;
  end

endmodule